// File: doc/BRIEF.md
# Bidirectional Ring Counter

This block is a small ring counter that keeps a single set bit circulating around a register of `WIDTH` flops. A 2-bit mode input picks one of four actions on each rising clock edge. The register can keep its value, rotate one place in either direction with end-around feedback, or load a fixed seed with only its most significant bit set. The direction can be changed at any cycle, so one counter steps through its one-hot positions forwards or backwards.

A synchronous active-high reset clears every bit to zero. All-zero is not a valid ring state, so hold and rotate leave a cleared register at zero. A user must apply the seed mode once to start the ring. The output comes straight from the state flops. Bit position `WIDTH-1` is the leftmost position and position 0 is the rightmost.

Top module: `ring_counter_bidir`

## Requirements
- R1: When `rst` is high at a rising edge, `count` is all zeros after that edge, whatever `mode` is.
- R2: Mode 2'b00 (hold) leaves `count` unchanged across the edge.
- R3: Mode 2'b01 (rotate right) sets `count[i]` to the old `count[i+1]` for i below `WIDTH-1`, and sets `count[WIDTH-1]` to the old `count[0]`.
- R4: Mode 2'b10 (rotate left) sets `count[i]` to the old `count[i-1]` for i above 0, and sets `count[0]` to the old `count[WIDTH-1]`.
- R5: Mode 2'b11 (seed) loads `count` with bit `WIDTH-1` set and all other bits clear (4'b1000 at the default width), from any prior value.
- R6: Once `count` holds exactly one set bit, hold and both rotations keep exactly one set bit.
- R7: When `count` is all zeros, the hold and rotate modes keep it all zeros until a seed load is made.
- R8: Reset has priority over the seed mode: with `rst` high and mode 2'b11, `count` still becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 hold, 01 rotate right, 10 rotate left, 11 load seed |
| count | output | WIDTH | Registered ring state; bit WIDTH-1 is leftmost |

## Verification
A wrong next-state wiring shows on `count` at the very next edge after the rotate is requested. A swapped neighbour or a missing wrap also moves the set bit to the wrong place or drops it. A bad wrap term appears only when the set bit sits at an end position, so the stimulus walks the bit through every position in both directions. A seed or decode fault shows up at once as an extra or missing set bit. A hold fault shows up as drift during long hold runs.

// File: rtl/ringctr_pkg.sv
package ringctr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD   = 2'b00,
    MODE_ROT_DN = 2'b01,
    MODE_ROT_UP = 2'b10,
    MODE_SEED   = 2'b11
  } ring_mode_e;

  typedef struct packed {
    logic hold;
    logic rot_dn;
    logic rot_up;
    logic seed;
  } ring_sel_t;

endpackage

// File: rtl/ringctr_decode.sv
module ringctr_decode
  import ringctr_pkg::*;
(
  input  logic [1:0] mode_i,
  output ring_sel_t  sel_o
);

  always_comb begin
    sel_o = '0;
    unique case (ring_mode_e'(mode_i))
      MODE_HOLD:   sel_o.hold   = 1'b1;
      MODE_ROT_DN: sel_o.rot_dn = 1'b1;
      MODE_ROT_UP: sel_o.rot_up = 1'b1;
      MODE_SEED:   sel_o.seed   = 1'b1;
      default:     sel_o.hold   = 1'b1;
    endcase
  end

endmodule

// File: rtl/ringctr_next.sv
module ringctr_next
  import ringctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  ring_sel_t        sel_i,
  output logic [WIDTH-1:0] nxt_o
);

  localparam logic [WIDTH-1:0] SEED_PATTERN = {1'b1, {(WIDTH-1){1'b0}}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // neighbour feeding this bit when rotating toward the low end
    localparam int DN_SRC = (i == WIDTH-1) ? 0 : i + 1;
    // neighbour feeding this bit when rotating toward the high end
    localparam int UP_SRC = (i == 0) ? WIDTH-1 : i - 1;

    always_comb begin
      nxt_o[i] = cur_i[i];
      if (sel_i.seed)        nxt_o[i] = SEED_PATTERN[i];
      else if (sel_i.rot_dn) nxt_o[i] = cur_i[DN_SRC];
      else if (sel_i.rot_up) nxt_o[i] = cur_i[UP_SRC];
    end
  end

endmodule

// File: rtl/ringctr_state.sv
module ringctr_state #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/ring_counter_bidir.sv
module ring_counter_bidir
  import ringctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] count
);

  ring_sel_t        sel;
  logic [WIDTH-1:0] nxt;

  ringctr_decode u_decode (
    .mode_i (mode),
    .sel_o  (sel)
  );

  ringctr_next #(.WIDTH(WIDTH)) u_next (
    .cur_i (count),
    .sel_i (sel),
    .nxt_o (nxt)
  );

  ringctr_state #(.WIDTH(WIDTH)) u_state (
    .clk (clk),
    .rst (rst),
    .d_i (nxt),
    .q_o (count)
  );

endmodule

// File: rtl/ringctr_chk.sv
module ringctr_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] SEED_PATTERN = {1'b1, {(WIDTH-1){1'b0}}};

  // R1 R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> count == '0);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> $stable(count));

  // R3
  rot_right_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |=> count == {$past(count[0]), $past(count[WIDTH-1:1])});

  // R4
  rot_left_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b10 |=> count == {$past(count[WIDTH-2:0]), $past(count[WIDTH-1])});

  // R5
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |=> count == SEED_PATTERN);

  // R6
  onehot_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(count) == 1 && mode != 2'b11) |=> $countones(count) == 1);

  // R7
  zero_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && mode != 2'b11) |=> count == '0);

endmodule

bind ring_counter_bidir ringctr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .mode  (mode),
  .count (count)
);

// File: tb/tb_ring_counter_bidir.sv
module tb_ring_counter_bidir;

  localparam int W = 4;

  typedef struct {
    logic [W-1:0] exp;
    bit           onehot;
    string        req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] count;

  item_t        sb[$];
  logic [W-1:0] model = '0;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  ring_counter_bidir #(.WIDTH(W)) dut (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .count (count)
  );

  // driver: one edge of stimulus, expected value pushed to the scoreboard
  task automatic step(input logic r, input logic [1:0] m, input string req);
    item_t it;
    @(negedge clk);
    rst  = r;
    mode = m;
    if (r) model = '0;
    else begin
      case (m)
        2'b01:   model = {model[0], model[W-1:1]};
        2'b10:   model = {model[W-2:0], model[W-1]};
        2'b11:   model = {1'b1, {(W-1){1'b0}}};
        default: model = model;
      endcase
    end
    it.exp    = model;
    it.onehot = (req == "R6");
    it.req    = req;
    sb.push_back(it);
  endtask

  // monitor: compares after each edge, away from the edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (count !== it.exp || (it.onehot && $countones(count) != 1)) begin
        n_fail++;
        $display("FAIL %s: count=%b expected=%b", it.req, count, it.exp);
      end
    end
  end

  initial begin
    step(1'b1, 2'b00, "R1");
    step(1'b1, 2'b11, "R8");
    // R7: cleared register stays zero without a seed
    step(1'b0, 2'b01, "R7");
    step(1'b0, 2'b10, "R7");
    step(1'b0, 2'b00, "R7");
    // R5 seed, twice
    step(1'b0, 2'b11, "R5");
    step(1'b0, 2'b11, "R5");
    // R3 walk right through all positions including the wrap
    for (int k = 0; k < W + 1; k++) step(1'b0, 2'b01, "R3");
    // R4 walk left through all positions including the wrap
    for (int k = 0; k < W + 2; k++) step(1'b0, 2'b10, "R4");
    // R2 hold run
    for (int k = 0; k < 5; k++) step(1'b0, 2'b00, "R2");
    // R6 mixed direction changes
    step(1'b0, 2'b01, "R6");
    step(1'b0, 2'b10, "R6");
    step(1'b0, 2'b10, "R6");
    step(1'b0, 2'b00, "R6");
    step(1'b0, 2'b01, "R6");
    step(1'b0, 2'b01, "R6");
    step(1'b0, 2'b01, "R6");
    // R5 seed from a non-seed position
    step(1'b0, 2'b11, "R5");
    step(1'b0, 2'b10, "R4");
    // R1 reset mid-run, then R8 reset over seed
    step(1'b1, 2'b01, "R1");
    step(1'b0, 2'b11, "R5");
    step(1'b1, 2'b11, "R8");
    step(1'b0, 2'b10, "R7");
    step(1'b0, 2'b00, "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule